// File: doc/BRIEF.md
# Shared-Window DMA Register Bank with Reload Latches

This block is the processor-facing register file of a multi-channel DMA engine whose CPU bus is 8 bits wide. Every channel owns a 16-bit mode word (two byte registers) and three 16-bit address/length registers: source, destination and count. All channels are reached through one small address window. A channel-select field in the status register decides which channel a mode, source, destination or count access lands on.

Each 16-bit register has two copies: a working copy that the transfer engine consumes, and a reload latch. The top bit of a channel's second mode byte is a latch-only flag. When it is clear, a completed 16-bit write lands in both copies. When it is set, only the latch changes. Wide values move through byte staging registers, so that a 16-bit value is never seen half-updated. The CPU writes the low byte and then the high byte. It reads the high byte and then the low byte. The status register also holds one sticky underflow flag per channel. The engine sets the flag and software clears it.

Top module: `dma_regbank`

## Requirements
- R1: The channel-select field (status bits [IDX_W-1:0]) routes every mode, source, destination and count access to the selected channel only. Other channels' registers do not change.
- R2: Mode byte 1 (address 1) is bits [7:0] of the channel's mode word and mode byte 2 (address 2) is bits [15:8]. Both read back what was written.
- R3: With the latch-only flag clear (mode word bit 15 = 0), a high-byte write (source 4, destination 6, count 8) sets both the working copy and the latch to {high byte, staged low byte}.
- R4: With the latch-only flag set, a high-byte write updates only the latch, and the working copy keeps its value.
- R5: A low-byte write (source 3, destination 5, count 7) changes no working copy and no latch. It only stages the byte.
- R6: A high-byte read returns the working copy's high byte and captures its low byte. The next low-byte read returns that captured byte, even if the channel select changed in between.
- R7: Read data appears on bus_rdata one cycle after bus_rd and holds until the next read.
- R8: A pulse on uf_set[c] sets underflow flag c (status bit 4+c). The flag stays set until software clears it.
- R9: A status write with bit 4+c equal to 0 clears flag c, and a 1 leaves it unchanged. A set in the same cycle overrides the clear.
- R10: After reset, all registers, latches, flags, the channel select and bus_rdata are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| uf_set | input | NCH | Per-channel underflow set pulse from the engine |
| uf_o | output | NCH | Underflow flags |
| mode_o | output | NCH*16 | Mode words, channel 0 in the low bits |
| src_o | output | NCH*16 | Working source copies |
| dst_o | output | NCH*16 | Working destination copies |
| cnt_o | output | NCH*16 | Working count copies |
| src_lat_o | output | NCH*16 | Source reload latches |
| dst_lat_o | output | NCH*16 | Destination reload latches |
| cnt_lat_o | output | NCH*16 | Count reload latches |

## Verification
Two actions can fall in the same cycle: the engine raising a channel's underflow set, and software writing 0 to clear that flag. The bench drives uf_set for channel 1 in the same cycle as a status write with that flag's bit at 0. It then checks through a status read, and at uf_o, that the flag remained set. A separate cycle with a clear and no set confirms that the clear takes effect on its own. The bench also interleaves a channel-select change between a high-byte read and the low-byte read that follows it. This shows that the captured byte comes from the first channel.

// File: rtl/dma_regbank_pkg.sv
// Shared constants for the DMA register bank: address map and register count.
// Assumes an address bus of at least 4 bits.
package dma_regbank_pkg;
    localparam int ADR_STAT    = 0;
    localparam int ADR_MODE1   = 1;
    localparam int ADR_MODE2   = 2;
    localparam int ADR_LO_BASE = 3;   // reg k: low = 3+2k, high = 4+2k
    localparam int NREG        = 3;   // source, destination, count
    localparam int UF_BIT0     = 4;   // underflow flag of channel c at bit 4+c
    localparam int LATCH_ONLY_BIT = 15;
    typedef logic [15:0] word_t;
endpackage

// File: rtl/dmareg_decode.sv
// Address decoder: turns a bus write/read into one-hot strobes.
// Assumes the address map from dma_regbank_pkg.
module dmareg_decode
    import dma_regbank_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    output logic              wr_stat,
    output logic              wr_m1,
    output logic              wr_m2,
    output logic              wr_lo_any,
    output logic [NREG-1:0]   wr_hi,
    output logic [NREG-1:0]   rd_hi
);
    logic [NREG-1:0] is_lo;
    logic [NREG-1:0] is_hi;

    // Match each 16-bit register's low and high byte address
    for (genvar k = 0; k < NREG; k++) begin : g_reg
        assign is_lo[k] = (int'(addr) == ADR_LO_BASE + 2*k);
        assign is_hi[k] = (int'(addr) == ADR_LO_BASE + 2*k + 1);
        assign wr_hi[k] = wr && is_hi[k];
        assign rd_hi[k] = rd && is_hi[k];
    end

    assign wr_stat   = wr && (int'(addr) == ADR_STAT);
    assign wr_m1     = wr && (int'(addr) == ADR_MODE1);
    assign wr_m2     = wr && (int'(addr) == ADR_MODE2);
    assign wr_lo_any = wr && (|is_lo);
endmodule

// File: rtl/dmareg_stage.sv
// Byte staging: holds the low byte of a pending 16-bit write, and the low
// byte captured by a high-byte read. Assumes one shared stage for all channels.
module dmareg_stage (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_lo,
    input  logic [7:0] wdata,
    input  logic       rd_hi,
    input  logic [7:0] rd_lo_src,
    output logic [7:0] wr_lo_q,
    output logic [7:0] rd_lo_q
);
    // Stage the low byte of a write until its high byte arrives
    always_ff @(posedge clk) begin
        if (!rst_n)     wr_lo_q <= '0;
        else if (wr_lo) wr_lo_q <= wdata;
    end

    // Capture the low byte alongside a high-byte read
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_lo_q <= '0;
        else if (rd_hi) rd_lo_q <= rd_lo_src;
    end
endmodule

// File: rtl/dmareg_chan.sv
// One channel: its mode word plus working copies and reload latches of the
// source, destination and count registers. Assumes strobes are already
// gated by the channel select (sel).
module dmareg_chan
    import dma_regbank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              wr_m1,
    input  logic              wr_m2,
    input  logic [NREG-1:0]   wr_hi,
    input  logic [7:0]        wdata,
    input  logic [7:0]        lo_q,
    output logic [15:0]       mode,
    output logic [NREG*16-1:0] work,
    output logic [NREG*16-1:0] lat
);
    logic latch_only;
    assign latch_only = mode[LATCH_ONLY_BIT];

    // Mode byte registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode <= '0;
        end else begin
            if (sel && wr_m1) mode[7:0]  <= wdata;
            if (sel && wr_m2) mode[15:8] <= wdata;
        end
    end

    for (genvar k = 0; k < NREG; k++) begin : g_reg
        // Latch takes every committed 16-bit write
        always_ff @(posedge clk) begin
            if (!rst_n)             lat[k*16 +: 16] <= '0;
            else if (sel && wr_hi[k]) lat[k*16 +: 16] <= {wdata, lo_q};
        end
        // Working copy takes it only when the latch-only flag is clear
        always_ff @(posedge clk) begin
            if (!rst_n)                            work[k*16 +: 16] <= '0;
            else if (sel && wr_hi[k] && !latch_only) work[k*16 +: 16] <= {wdata, lo_q};
        end
    end
endmodule

// File: rtl/dmareg_status.sv
// Status register: channel select field and sticky underflow flags.
// Assumes NCH <= 4 so flags fit in bits 7:4.
module dmareg_status
    import dma_regbank_pkg::*;
#(
    parameter int NCH   = 2,
    parameter int IDX_W = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_stat,
    input  logic [7:0]       wdata,
    input  logic [NCH-1:0]   uf_set,
    output logic [IDX_W-1:0] idx_q,
    output logic [NCH-1:0]   uf_q,
    output logic [7:0]       stat_byte
);
    // Channel select field
    always_ff @(posedge clk) begin
        if (!rst_n)       idx_q <= '0;
        else if (wr_stat) idx_q <= wdata[IDX_W-1:0];
    end

    for (genvar c = 0; c < NCH; c++) begin : g_uf
        // Sticky flag: engine set wins over a software clear
        always_ff @(posedge clk) begin
            if (!rst_n)                            uf_q[c] <= 1'b0;
            else if (uf_set[c])                    uf_q[c] <= 1'b1;
            else if (wr_stat && !wdata[UF_BIT0+c]) uf_q[c] <= 1'b0;
        end
    end

    // Assemble the readable status byte
    always_comb begin
        stat_byte = '0;
        stat_byte[IDX_W-1:0] = idx_q;
        stat_byte[UF_BIT0 +: NCH] = uf_q;
    end
endmodule

// File: rtl/dma_regbank.sv
// Top: shared-window register bank for NCH DMA channels on an 8-bit bus.
// Assumes single-cycle strobes; read data is registered.
module dma_regbank
    import dma_regbank_pkg::*;
#(
    parameter int NCH    = 2,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic [NCH-1:0]    uf_set,
    output logic [NCH-1:0]    uf_o,
    output logic [NCH*16-1:0] mode_o,
    output logic [NCH*16-1:0] src_o,
    output logic [NCH*16-1:0] dst_o,
    output logic [NCH*16-1:0] cnt_o,
    output logic [NCH*16-1:0] src_lat_o,
    output logic [NCH*16-1:0] dst_lat_o,
    output logic [NCH*16-1:0] cnt_lat_o
);
    localparam int IDX_W = (NCH > 1) ? $clog2(NCH) : 1;
    localparam int CW    = NREG * 16;

    logic              wr_stat, wr_m1, wr_m2, wr_lo_any;
    logic [NREG-1:0]   wr_hi, rd_hi;
    logic [IDX_W-1:0]  idx_q;
    logic [NCH-1:0]    uf_q;
    logic [7:0]        stat_byte, wr_lo_q, rd_lo_q, rd_lo_src, rd_next;
    logic [NCH*CW-1:0] work_flat, lat_flat;
    logic [15:0]       mode_sel;
    logic [CW-1:0]     work_sel;

    dmareg_decode #(.ADDR_W(ADDR_W)) i_dec (
        .addr(bus_addr), .wr(bus_wr), .rd(bus_rd),
        .wr_stat(wr_stat), .wr_m1(wr_m1), .wr_m2(wr_m2),
        .wr_lo_any(wr_lo_any), .wr_hi(wr_hi), .rd_hi(rd_hi)
    );

    dmareg_status #(.NCH(NCH), .IDX_W(IDX_W)) i_stat (
        .clk(clk), .rst_n(rst_n), .wr_stat(wr_stat), .wdata(bus_wdata),
        .uf_set(uf_set), .idx_q(idx_q), .uf_q(uf_q), .stat_byte(stat_byte)
    );

    dmareg_stage i_stage (
        .clk(clk), .rst_n(rst_n), .wr_lo(wr_lo_any), .wdata(bus_wdata),
        .rd_hi(|rd_hi), .rd_lo_src(rd_lo_src),
        .wr_lo_q(wr_lo_q), .rd_lo_q(rd_lo_q)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic chan_sel;
        assign chan_sel = (int'(idx_q) == c);
        dmareg_chan i_chan (
            .clk(clk), .rst_n(rst_n), .sel(chan_sel),
            .wr_m1(wr_m1), .wr_m2(wr_m2), .wr_hi(wr_hi),
            .wdata(bus_wdata), .lo_q(wr_lo_q),
            .mode(mode_o[c*16 +: 16]),
            .work(work_flat[c*CW +: CW]),
            .lat(lat_flat[c*CW +: CW])
        );
        // Split each channel's flat vectors onto the named output ports
        assign src_o[c*16 +: 16]     = work_flat[c*CW +:  16];
        assign dst_o[c*16 +: 16]     = work_flat[c*CW + 16 +: 16];
        assign cnt_o[c*16 +: 16]     = work_flat[c*CW + 32 +: 16];
        assign src_lat_o[c*16 +: 16] = lat_flat[c*CW +:  16];
        assign dst_lat_o[c*16 +: 16] = lat_flat[c*CW + 16 +: 16];
        assign cnt_lat_o[c*16 +: 16] = lat_flat[c*CW + 32 +: 16];
    end

    assign uf_o = uf_q;

    // Pick the selected channel's mode and working registers
    always_comb begin
        mode_sel = '0;
        work_sel = '0;
        for (int c = 0; c < NCH; c++) begin
            if (int'(idx_q) == c) begin
                mode_sel = mode_o[c*16 +: 16];
                work_sel = work_flat[c*CW +: CW];
            end
        end
    end

    // Low byte to capture on a high-byte read, and the next read data
    always_comb begin
        rd_lo_src = '0;
        rd_next   = '0;
        if (int'(bus_addr) == ADR_STAT)  rd_next = stat_byte;
        if (int'(bus_addr) == ADR_MODE1) rd_next = mode_sel[7:0];
        if (int'(bus_addr) == ADR_MODE2) rd_next = mode_sel[15:8];
        for (int k = 0; k < NREG; k++) begin
            if (int'(bus_addr) == ADR_LO_BASE + 2*k) rd_next = rd_lo_q;
            if (int'(bus_addr) == ADR_LO_BASE + 2*k + 1) begin
                rd_next   = work_sel[k*16 + 8 +: 8];
                rd_lo_src = work_sel[k*16 +: 8];
            end
        end
    end

    // Registered read port
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_next;
    end
endmodule

// File: rtl/dma_regbank_chk.sv
// Checker for dma_regbank, bound to every instance. Observes ports and
// the select/flag/flat register state.
module dma_regbank_chk
    import dma_regbank_pkg::*;
#(
    parameter int NCH    = 2,
    parameter int ADDR_W = 4,
    parameter int IDX_W  = 1
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [ADDR_W-1:0]      bus_addr,
    input logic                   bus_wr,
    input logic                   bus_rd,
    input logic [7:0]             bus_wdata,
    input logic [7:0]             bus_rdata,
    input logic [NCH-1:0]         uf_set,
    input logic [NCH-1:0]         uf_q,
    input logic [IDX_W-1:0]       idx_q,
    input logic [NCH*16-1:0]      mode_o,
    input logic [NCH*NREG*16-1:0] work_flat,
    input logic [NCH*NREG*16-1:0] lat_flat
);
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata)); // R7

    AST_LO_STAGE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && ((int'(bus_addr) == ADR_LO_BASE) || (int'(bus_addr) == ADR_LO_BASE + 2)
                    || (int'(bus_addr) == ADR_LO_BASE + 4)))
        |=> ($stable(work_flat) && $stable(lat_flat))); // R5

    for (genvar c = 0; c < NCH; c++) begin : g_c
        AST_UF_SET: assert property (@(posedge clk) disable iff (!rst_n)
            uf_set[c] |=> uf_q[c]); // R8
        AST_UF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && int'(bus_addr) == ADR_STAT && !bus_wdata[UF_BIT0+c] && !uf_set[c])
            |=> !uf_q[c]); // R9
        AST_UNSEL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && int'(bus_addr) != ADR_STAT && int'(idx_q) != c)
            |=> ($stable(work_flat[c*NREG*16 +: NREG*16])
                 && $stable(lat_flat[c*NREG*16 +: NREG*16])
                 && $stable(mode_o[c*16 +: 16]))); // R1
        for (genvar k = 0; k < NREG; k++) begin : g_k
            AST_LATCH_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
                (bus_wr && int'(bus_addr) == ADR_LO_BASE + 2*k + 1 && int'(idx_q) == c
                 && mode_o[c*16 + LATCH_ONLY_BIT])
                |=> $stable(work_flat[(c*NREG+k)*16 +: 16])); // R4
            AST_BOTH_COPIES: assert property (@(posedge clk) disable iff (!rst_n)
                (bus_wr && int'(bus_addr) == ADR_LO_BASE + 2*k + 1 && int'(idx_q) == c
                 && !mode_o[c*16 + LATCH_ONLY_BIT])
                |=> (work_flat[(c*NREG+k)*16 +: 16] == lat_flat[(c*NREG+k)*16 +: 16])); // R3
        end
    end
endmodule

bind dma_regbank dma_regbank_chk #(.NCH(NCH), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .uf_set(uf_set), .uf_q(uf_q),
    .idx_q(idx_q), .mode_o(mode_o), .work_flat(work_flat), .lat_flat(lat_flat)
);

// File: tb/test_dma_regbank.sv
module test_dma_regbank;
    localparam int NCH = 2;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [3:0] bus_addr = '0;
    logic bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [NCH-1:0] uf_set = '0;
    logic [NCH-1:0] uf_o;
    logic [NCH*16-1:0] mode_o, src_o, dst_o, cnt_o, src_lat_o, dst_lat_o, cnt_lat_o;

    int checks = 0;
    int fails  = 0;
    logic pend = 1'b0;
    typedef struct { logic [7:0] val; string req; } exp_t;
    exp_t sb[$];

    always #4 clk = ~clk;   // 125 MHz

    dma_regbank #(.NCH(NCH), .ADDR_W(4)) i_dma_regbank (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .uf_set(uf_set), .uf_o(uf_o), .mode_o(mode_o), .src_o(src_o),
        .dst_o(dst_o), .cnt_o(cnt_o), .src_lat_o(src_lat_o),
        .dst_lat_o(dst_lat_o), .cnt_lat_o(cnt_lat_o)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = 4'(a); bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    // Driver: issue a read and push its expected value to the scoreboard
    task automatic rd(input int a, input logic [7:0] exp, input string req);
        @(negedge clk);
        bus_addr = 4'(a); bus_rd = 1'b1;
        sb.push_back('{val: exp, req: req});
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    // Monitor: a read issued last cycle has its data ready now
    always @(posedge clk) pend <= bus_rd && rst_n;
    always @(negedge clk) begin
        if (pend) begin
            exp_t e;
            if (sb.size() == 0) begin
                checks++; fails++;
                $display("FAIL scoreboard: unexpected read data %h", bus_rdata);
            end else begin
                e = sb.pop_front();
                chk({24'h0, bus_rdata}, {24'h0, e.val}, e.req);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        chk({16'h0, src_o[15:0]}, 0, "R10 src");
        chk({16'h0, cnt_lat_o[31:16]}, 0, "R10 cnt latch");
        chk({30'h0, uf_o}, 0, "R10 flags");
        chk({24'h0, bus_rdata}, 0, "R10 rdata");
        rd(0, 8'h00, "R10 status");

        // Channel 0, both copies
        wr(0, 8'h00);
        wr(1, 8'h12);
        wr(2, 8'h34);
        wr(3, 8'hCD);
        chk({16'h0, src_o[15:0]}, 0, "R5 work after low byte");
        chk({16'h0, src_lat_o[15:0]}, 0, "R5 latch after low byte");
        wr(4, 8'hAB);
        chk({16'h0, src_o[15:0]}, 32'hABCD, "R3 work");
        chk({16'h0, src_lat_o[15:0]}, 32'hABCD, "R3 latch");

        // Channel 1, latch-only
        wr(0, 8'h01);
        wr(1, 8'h56);
        wr(2, 8'h80);
        wr(5, 8'h22);
        wr(6, 8'h11);
        chk({16'h0, dst_o[31:16]}, 0, "R4 work unchanged");
        chk({16'h0, dst_lat_o[31:16]}, 32'h1122, "R4 latch");
        chk({16'h0, dst_lat_o[15:0]}, 0, "R1 ch0 untouched");
        chk({16'h0, mode_o[15:0]}, 32'h3412, "R1 ch0 mode untouched");
        rd(1, 8'h56, "R2 ch1 mode1");
        rd(2, 8'h80, "R2 ch1 mode2");
        rd(6, 8'h00, "R4 ch1 dst high read");
        wr(0, 8'h00);
        rd(1, 8'h12, "R1 R2 ch0 mode1");
        rd(2, 8'h34, "R1 R2 ch0 mode2");

        // R6: capture survives a channel switch
        rd(4, 8'hAB, "R6 high read");
        wr(0, 8'h01);
        rd(3, 8'hCD, "R6 captured low");

        // Count on ch1: latch-only, then both
        wr(7, 8'hFF);
        wr(8, 8'hFF);
        chk({16'h0, cnt_lat_o[31:16]}, 32'hFFFF, "R4 cnt latch");
        chk({16'h0, cnt_o[31:16]}, 0, "R4 cnt work");
        wr(2, 8'h00);
        wr(7, 8'h01);
        wr(8, 8'h02);
        chk({16'h0, cnt_o[31:16]}, 32'h0201, "R3 cnt work");
        chk({16'h0, cnt_o[15:0]}, 0, "R1 ch0 cnt");

        // R7: read data holds with no read
        rd(8, 8'h02, "R7 read");
        repeat (3) @(negedge clk);
        chk({24'h0, bus_rdata}, 32'h02, "R7 hold");

        // R8/R9 flags
        @(negedge clk); uf_set = 2'b01;
        @(negedge clk); uf_set = 2'b00;
        chk({30'h0, uf_o}, 1, "R8 set");
        rd(0, 8'h11, "R8 status read");
        wr(0, 8'h31);
        chk({30'h0, uf_o}, 1, "R9 write 1 keeps");
        wr(0, 8'h01);
        chk({30'h0, uf_o}, 0, "R9 clear");
        @(negedge clk);
        bus_addr = 4'd0; bus_wdata = 8'h00; bus_wr = 1'b1; uf_set = 2'b10;
        @(negedge clk);
        bus_wr = 1'b0; uf_set = 2'b00;
        chk({30'h0, uf_o}, 2, "R9 set beats clear");
        rd(0, 8'h20, "R9 status after collision");

        repeat (3) @(negedge clk);
        chk(sb.size(), 0, "scoreboard drained");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule